// File: doc/BRIEF.md
# Increment-and-Skip Instruction Executor

This block runs two conditional-skip increment instructions of a small 8-bit accumulator core. An instruction cycle has four phases, indexed by `phase_i`: decode, operand read, increment and destination write. In the decode phase the 16-bit word is matched against the two opcodes and its fields are captured. The data address is formed from the 8-bit file field in one of three ways: a banked address using the bank-select input, a fixed split access window, or an indexed offset from a pointer. In the read phase the operand is fetched. In the increment phase it is incremented modulo 256. In the write phase the result goes either to the working register or back to data memory.

One opcode skips when the incremented value is zero and the other skips when it is non-zero. A skip is signalled to the fetch stage in the write phase. The executor then squashes the following one or two whole instruction cycles, and during those cycles nothing is read, written or skipped. The fetch stage says whether the prefetched word opens a two-word instruction, and that selects the longer squash. Status flags, the program counter and fetch are outside the block.

Top module: `incskip_exec`

## Requirements
- R1: An instruction is recognised in the decode phase (`phase_i`=0) only when bits 15:10 are 6'b001111 (skip-on-zero) or 6'b010010 (skip-on-non-zero). Bit 9 selects the destination, bit 8 selects the addressing mode and bits 7:0 are the file field. Any other word causes no read, no write and no skip.
- R2: With bit 8 = 1, `dm_addr_o` = {`bsr_i`, file field}.
- R3: With bit 8 = 0 and indexed mode not selected, file fields 0x00–0x5F address {4'h0, field} and 0x60–0xFF address {4'hF, field}.
- R4: With bit 8 = 0, `ext_mode_i` = 1 and file field ≤ 0x5F, `dm_addr_o` = (`idx_ptr_i` + field) mod 4096.
- R5: `dm_re_o` is high only in the read phase (`phase_i`=1) of a recognised instruction. The result is the operand read then, plus one, modulo 256.
- R6: In the write phase (`phase_i`=3), bit 9 = 1 raises `dm_we_o` with the result on `dm_wdata_o`. Bit 9 = 0 raises `w_we_o` with the result on `w_wdata_o`. The two strobes are never high together, and neither is high outside the write phase.
- R7: `skip_o` is high in the write phase of a skip-on-zero instruction exactly when the result is 0x00. For a skip-on-non-zero instruction it is high exactly when the result is not 0x00.
- R8: After a skip, `squash_o` is high for the next one instruction cycle, or for the next two cycles if `next_two_word_i` was high in the skipping write phase. During those cycles any instruction word is ignored: no read, no write, no skip.
- R9: While `rst_ni` is low, every strobe, `skip_o` and `squash_o` are low, and any pending squash is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_i | input | 2 | Current phase: 0 decode, 1 read, 2 increment, 3 write |
| instr_i | input | 16 | Instruction word, sampled in phase 0 |
| bsr_i | input | 4 | Bank-select value for banked addressing |
| ext_mode_i | input | 1 | Enables indexed addressing for low file fields |
| idx_ptr_i | input | 12 | Index pointer for indexed addressing |
| next_two_word_i | input | 1 | Prefetched word starts a two-word instruction |
| dm_addr_o | output | 12 | Data-memory address |
| dm_re_o | output | 1 | Data-memory read strobe |
| dm_rdata_i | input | 8 | Data-memory read data |
| dm_we_o | output | 1 | Data-memory write strobe |
| dm_wdata_o | output | 8 | Data-memory write data |
| w_we_o | output | 1 | Working-register write strobe |
| w_wdata_o | output | 8 | Working-register write data |
| skip_o | output | 1 | Skip request toward fetch |
| squash_o | output | 1 | Current instruction cycle is being squashed |

## Verification
The hardest state to reach is a two-cycle squash in which valid, matching instructions sit on `instr_i` throughout. Reaching it needs a skip whose polarity agrees with a wrap or non-wrap operand, with `next_two_word_i` held high in that same write phase. The bench gets there with vectors built for this case: an operand of 0xFF for the zero variant, and any non-0xFF operand for the non-zero variant. It then holds a recognised instruction during every squashed phase and checks that the strobes stay quiet. A reset asserted while a squash is pending is also applied, to show that the pending squash is dropped.

// File: rtl/incskip_pkg.sv
package incskip_pkg;
  localparam int DATA_W  = 8;
  localparam int FILE_W  = 8;
  localparam int BANK_W  = 4;
  localparam int ADDR_W  = BANK_W + FILE_W;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0] OPC_SKZ  = 6'b001111;
  localparam logic [OPC_W-1:0] OPC_SKNZ = 6'b010010;

  typedef enum logic [1:0] {
    PH_DEC = 2'd0,
    PH_RD  = 2'd1,
    PH_EXE = 2'd2,
    PH_WR  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SKZ  = 2'd1,
    OP_SKNZ = 2'd2
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              to_file;
    logic              banked;
    logic [FILE_W-1:0] fa;
  } dec_t;
endpackage

// File: rtl/incskip_decode.sv
module incskip_decode
  import incskip_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  logic [OPC_W-1:0] opc;
  assign opc = instr_i[INSTR_W-1:OPC_LSB];

  always_comb begin
    dec_o.op      = OP_NONE;
    dec_o.to_file = instr_i[FILE_W+1];
    dec_o.banked  = instr_i[FILE_W];
    dec_o.fa      = instr_i[FILE_W-1:0];
    if (opc == OPC_SKZ)       dec_o.op = OP_SKZ;
    else if (opc == OPC_SKNZ) dec_o.op = OP_SKNZ;
  end
endmodule

// File: rtl/incskip_addr.sv
module incskip_addr
  import incskip_pkg::*;
#(
  parameter bit                HAS_INDEXED = 1'b1,
  parameter logic [FILE_W-1:0] ACC_LIMIT   = 8'h60,
  parameter logic [BANK_W-1:0] HI_BANK     = '1
) (
  input  logic              banked_i,
  input  logic [FILE_W-1:0] fa_i,
  input  logic [BANK_W-1:0] bsr_i,
  input  logic              ext_mode_i,
  input  logic [ADDR_W-1:0] idx_ptr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic              low_half;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] bank_addr;

  assign low_half  = fa_i < ACC_LIMIT;
  assign acc_addr  = {(low_half ? {BANK_W{1'b0}} : HI_BANK), fa_i};
  assign bank_addr = {bsr_i, fa_i};

  generate
    if (HAS_INDEXED) begin : g_idx
      logic [ADDR_W-1:0] idx_addr;
      assign idx_addr = idx_ptr_i + {{(ADDR_W-FILE_W){1'b0}}, fa_i};
      always_comb begin
        if (banked_i)                  addr_o = bank_addr;
        else if (ext_mode_i && low_half) addr_o = idx_addr;
        else                           addr_o = acc_addr;
      end
    end else begin : g_noidx
      logic unused_idx;
      assign unused_idx = ext_mode_i ^ (^idx_ptr_i);
      assign addr_o = banked_i ? bank_addr : acc_addr;
    end
  endgenerate
endmodule

// File: rtl/incskip_alu.sv
module incskip_alu
  import incskip_pkg::*;
(
  input  op_e               op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              take_o
);
  logic is_zero;
  assign sum_o   = opnd_i + {{(DATA_W-1){1'b0}}, 1'b1};
  assign is_zero = (res_i == '0);

  always_comb begin
    unique case (op_i)
      OP_SKZ:  take_o = is_zero;
      OP_SKNZ: take_o = !is_zero;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/incskip_seq.sv
module incskip_seq
  import incskip_pkg::*;
#(
  parameter int SQ_W = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  input  logic   hit_i,
  input  logic   take_i,
  input  logic   next_two_word_i,
  output logic   active_o,
  output logic   squash_o,
  output logic   skip_o
);
  localparam logic [SQ_W-1:0] SQ_ONE = SQ_W'(1);
  localparam logic [SQ_W-1:0] SQ_TWO = SQ_W'(2);

  logic            active_q;
  logic [SQ_W-1:0] sq_cnt_q;

  assign squash_o = (sq_cnt_q != '0);
  assign active_o = active_q;
  assign skip_o   = active_q && (phase_i == PH_WR) && take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sq_cnt_q <= '0;
    end else begin
      unique case (phase_i)
        PH_DEC: active_q <= hit_i && !squash_o;
        PH_WR: begin
          active_q <= 1'b0;
          if (skip_o)        sq_cnt_q <= next_two_word_i ? SQ_TWO : SQ_ONE;
          else if (squash_o) sq_cnt_q <= sq_cnt_q - SQ_ONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/incskip_exec.sv
module incskip_exec
  import incskip_pkg::*;
#(
  parameter bit                HAS_INDEXED = 1'b1,
  parameter logic [FILE_W-1:0] ACC_LIMIT   = 8'h60,
  parameter logic [BANK_W-1:0] HI_BANK     = 4'hF,
  parameter int                SQ_W        = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         phase_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [BANK_W-1:0]  bsr_i,
  input  logic               ext_mode_i,
  input  logic [ADDR_W-1:0]  idx_ptr_i,
  input  logic               next_two_word_i,
  output logic [ADDR_W-1:0]  dm_addr_o,
  output logic               dm_re_o,
  input  logic [DATA_W-1:0]  dm_rdata_i,
  output logic               dm_we_o,
  output logic [DATA_W-1:0]  dm_wdata_o,
  output logic               w_we_o,
  output logic [DATA_W-1:0]  w_wdata_o,
  output logic               skip_o,
  output logic               squash_o
);
  phase_e            ph;
  dec_t              dec_live, dec_q;
  logic [DATA_W-1:0] opnd_q, res_q, sum;
  logic              take, active;

  assign ph = phase_e'(phase_i);

  incskip_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec_live)
  );

  incskip_addr #(
    .HAS_INDEXED (HAS_INDEXED),
    .ACC_LIMIT   (ACC_LIMIT),
    .HI_BANK     (HI_BANK)
  ) u_addr (
    .banked_i   (dec_q.banked),
    .fa_i       (dec_q.fa),
    .bsr_i      (bsr_i),
    .ext_mode_i (ext_mode_i),
    .idx_ptr_i  (idx_ptr_i),
    .addr_o     (dm_addr_o)
  );

  incskip_alu u_alu (
    .op_i   (dec_q.op),
    .opnd_i (opnd_q),
    .res_i  (res_q),
    .sum_o  (sum),
    .take_o (take)
  );

  incskip_seq #(.SQ_W(SQ_W)) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .phase_i         (ph),
    .hit_i           (dec_live.op != OP_NONE),
    .take_i          (take),
    .next_two_word_i (next_two_word_i),
    .active_o        (active),
    .squash_o        (squash_o),
    .skip_o          (skip_o)
  );

  // field latch and datapath pipeline across phases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q  <= '0;
      opnd_q <= '0;
      res_q  <= '0;
    end else begin
      if (ph == PH_DEC && !squash_o) dec_q  <= dec_live;
      if (ph == PH_RD && active)     opnd_q <= dm_rdata_i;
      if (ph == PH_EXE && active)    res_q  <= sum;
    end
  end

  assign dm_re_o    = active && (ph == PH_RD);
  assign dm_we_o    = active && (ph == PH_WR) && dec_q.to_file;
  assign w_we_o     = active && (ph == PH_WR) && !dec_q.to_file;
  assign dm_wdata_o = res_q;
  assign w_wdata_o  = res_q;
endmodule

// File: rtl/incskip_exec_chk.sv
module incskip_exec_chk
  import incskip_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        phase_i,
  input logic [DATA_W-1:0] dm_rdata_i,
  input logic              dm_re_o,
  input logic              dm_we_o,
  input logic [DATA_W-1:0] dm_wdata_o,
  input logic              w_we_o,
  input logic [DATA_W-1:0] w_wdata_o,
  input logic              skip_o,
  input logic              squash_o
);
  assert_re_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_re_o |-> phase_i == 2'd1);

  assert_file_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we_o |-> dm_wdata_o == DATA_W'($past(dm_rdata_i, 2) + 1'b1));

  assert_w_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_we_o |-> w_wdata_o == DATA_W'($past(dm_rdata_i, 2) + 1'b1));

  assert_we_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dm_we_o || w_we_o) |-> phase_i == 2'd3);

  assert_we_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dm_we_o && w_we_o));

  assert_skip_with_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (dm_we_o || w_we_o));

  assert_skip_starts_squash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> squash_o);

  assert_squash_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> !(dm_re_o || dm_we_o || w_we_o || skip_o));

  assert_squash_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(squash_o) || $fell(squash_o)) |-> $past(phase_i) == 2'd3);
endmodule

bind incskip_exec incskip_exec_chk u_chk (.*);

// File: tb/sim_incskip_exec.sv
module sim_incskip_exec;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  phase_i = '0;
  logic [15:0] instr_i = '0;
  logic [3:0]  bsr_i = '0;
  logic        ext_mode_i = 1'b0;
  logic [11:0] idx_ptr_i = '0;
  logic        next_two_word_i = 1'b0;
  logic [11:0] dm_addr_o;
  logic        dm_re_o;
  logic [7:0]  dm_rdata_i = '0;
  logic        dm_we_o;
  logic [7:0]  dm_wdata_o;
  logic        w_we_o;
  logic [7:0]  w_wdata_o;
  logic        skip_o;
  logic        squash_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  incskip_exec u0 (
    .clk_i(clk), .rst_ni, .phase_i, .instr_i, .bsr_i, .ext_mode_i, .idx_ptr_i,
    .next_two_word_i, .dm_addr_o, .dm_re_o, .dm_rdata_i, .dm_we_o, .dm_wdata_o,
    .w_we_o, .w_wdata_o, .skip_o, .squash_o
  );

  // dest: 0 none, 1 file, 2 working register
  typedef struct packed {
    logic [15:0] ins;
    logic [3:0]  bsr;
    logic        ext;
    logic [11:0] idx;
    logic [7:0]  rd;
    logic        tw;
    logic [11:0] addr;
    logic [1:0]  dest;
    logic        skip;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'h3F25, 4'h3, 1'b0, 12'h000, 8'hFF, 1'b0, 12'h325, 2'd1, 1'b1},
    '{16'h3C70, 4'h0, 1'b0, 12'h000, 8'h10, 1'b0, 12'hF70, 2'd2, 1'b0},
    '{16'h3E40, 4'h0, 1'b0, 12'h000, 8'h7F, 1'b0, 12'h040, 2'd1, 1'b0},
    '{16'h3E5F, 4'h0, 1'b1, 12'h123, 8'hFF, 1'b1, 12'h182, 2'd1, 1'b1},
    '{16'h4B60, 4'hA, 1'b0, 12'h000, 8'h00, 1'b0, 12'hA60, 2'd1, 1'b1},
    '{16'h4860, 4'h0, 1'b1, 12'h123, 8'hFF, 1'b0, 12'hF60, 2'd2, 1'b0},
    '{16'h4A05, 4'h0, 1'b1, 12'hFFE, 8'h41, 1'b1, 12'h003, 2'd1, 1'b1},
    '{16'h4900, 4'hF, 1'b1, 12'h000, 8'hFF, 1'b0, 12'hF00, 2'd2, 1'b0},
    '{16'h2C10, 4'h0, 1'b0, 12'h000, 8'hFF, 1'b0, 12'h000, 2'd0, 1'b0},
    '{16'h4C00, 4'h0, 1'b0, 12'h000, 8'h00, 1'b0, 12'h000, 2'd0, 1'b0},
    '{16'h3E60, 4'h0, 1'b1, 12'h123, 8'h00, 1'b0, 12'hF60, 2'd1, 1'b0},
    '{16'h3E5F, 4'h0, 1'b0, 12'h000, 8'h3C, 1'b0, 12'h05F, 2'd1, 1'b0},
    '{16'h4A7F, 4'h5, 1'b0, 12'h000, 8'hFE, 1'b1, 12'hF7F, 2'd1, 1'b1},
    '{16'h3D00, 4'h0, 1'b0, 12'h000, 8'h00, 1'b0, 12'h000, 2'd2, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] ph, input logic [15:0] ins,
                       input logic [7:0] rd, input logic tw);
    @(negedge clk);
    phase_i = ph; instr_i = ins; dm_rdata_i = rd; next_two_word_i = tw;
    #1;
  endtask

  // one squashed cycle carrying a recognised instruction that would otherwise skip
  task automatic squash_cycle();
    for (int p = 0; p < 4; p++) begin
      drive(2'(p), 16'h3E00, 8'hFF, 1'b1);
      chk(squash_o == 1'b1, "R8", "squash_o held", int'(squash_o), 1);
      chk(!(dm_re_o || dm_we_o || w_we_o || skip_o), "R8", "quiet in squash",
          int'({dm_re_o, dm_we_o, w_we_o, skip_o}), 0);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit do_squash);
    logic [7:0] res;
    string areq;
    res = v.rd + 8'd1;
    if (v.ins[8])                                 areq = "R2";
    else if (v.ext && v.ins[7:0] <= 8'h5F)        areq = "R4";
    else                                          areq = "R3";
    bsr_i = v.bsr; ext_mode_i = v.ext; idx_ptr_i = v.idx;
    drive(2'd0, v.ins, v.rd, v.tw);
    chk(squash_o == 1'b0, "R8", "no squash at decode", int'(squash_o), 0);
    drive(2'd1, v.ins, v.rd, v.tw);
    chk(dm_re_o == (v.dest != 2'd0), "R1", "read strobe", int'(dm_re_o), int'(v.dest != 2'd0));
    if (v.dest != 2'd0) chk(dm_addr_o == v.addr, areq, "address", int'(dm_addr_o), int'(v.addr));
    drive(2'd2, v.ins, v.rd, v.tw);
    chk(dm_re_o == 1'b0, "R5", "no read in phase 2", int'(dm_re_o), 0);
    drive(2'd3, v.ins, v.rd, v.tw);
    chk(dm_we_o == (v.dest == 2'd1), "R6", "file strobe", int'(dm_we_o), int'(v.dest == 2'd1));
    chk(w_we_o == (v.dest == 2'd2), "R6", "w strobe", int'(w_we_o), int'(v.dest == 2'd2));
    if (v.dest == 2'd1) chk(dm_wdata_o == res, "R5", "file data", int'(dm_wdata_o), int'(res));
    if (v.dest == 2'd2) chk(w_wdata_o == res, "R5", "w data", int'(w_wdata_o), int'(res));
    chk(skip_o == v.skip, "R7", "skip", int'(skip_o), int'(v.skip));
    if (do_squash && v.skip) begin
      squash_cycle();
      if (v.tw) squash_cycle();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({dm_re_o, dm_we_o, w_we_o, skip_o, squash_o} == 5'b0, "R9", "reset outputs",
        int'({dm_re_o, dm_we_o, w_we_o, skip_o, squash_o}), 0);
    @(negedge clk); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b1);

    // R9: reset while a two-cycle squash is pending cancels it
    run_vec(VECS[3], 1'b0);
    @(negedge clk); rst_ni = 1'b0; #1;
    chk({dm_re_o, dm_we_o, w_we_o, skip_o, squash_o} == 5'b0, "R9", "reset mid squash",
        int'({dm_re_o, dm_we_o, w_we_o, skip_o, squash_o}), 0);
    @(negedge clk); rst_ni = 1'b1;
    run_vec(VECS[2], 1'b1);

    // R8: single squash then immediate next instruction executes
    run_vec(VECS[4], 1'b1);
    run_vec(VECS[1], 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule